// File: doc/BRIEF.md
# Re-encoding Channel Error Monitor

This block sits beside a convolutional (Viterbi) decoder and estimates how many channel bit errors the received stream carries, without any known test pattern. It takes the decoder's output bits with their qualifier and feeds them through its own convolutional encoder, which uses the same generator polynomials as the transmitter. It then compares the regenerated code bits with the symbols that actually came in from the channel. Those symbols are hard-sliced from their soft values and held in a delay line so that they line up with the decoder's latency. The decoder is taken to be error-free, so every disagreement is counted as a channel error.

Mismatches are summed over a window of 2^WIN_LOG2 clocks. At the last clock of each window the total is published on a count output with a single-cycle strobe, and the sum starts again from zero. The published value stays on the output until the next strobe. The sum saturates and never wraps.

Top module: `ber_monitor`

## Requirements
- R1: Each soft rail is sliced to one hard bit. In signed mode a value with sign bit 0 (zero or positive) gives 1 and a negative value gives 0. In unsigned mode the MSB is the hard bit. Rail r of `rx_sym` occupies bits [r*SOFT_W +: SOFT_W].
- R2: The re-encoder holds the last K-1 decoded bits. Code rail r is the XOR of the bits selected by `GENPOLY[r*K +: K]` over {current bit, newest past bit, ..., oldest past bit}, with the polynomial MSB on the current bit. The history advances only when `dec_valid` is high.
- R3: A symbol pair sampled at clock edge n is compared with the re-encoding of the decoded bit sampled at edge n+DEC_LATENCY. The delay line depth is DEC_LATENCY plus the one-stage re-encoder pipeline.
- R4: Each comparison adds the number of differing rails (0 to N_RAIL) to the running sum. A comparison happens only when the decoded bit was qualified by `dec_valid`, so received symbols paired with an unqualified slot are never counted.
- R5: Windows are 2^WIN_LOG2 clocks long and the first one starts at reset release. At the last edge of each window, `ber` takes the window total, including that edge's comparison, and `ber_valid` is high for exactly that one cycle. The sum then restarts at zero.
- R6: The running sum, and hence `ber`, saturates at 2^CNT_W-1.
- R7: After reset `ber` is 0 and `ber_valid` is 0. Between strobes `ber` holds its last published value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one received symbol pair per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sym | input | N_RAIL*SOFT_W | Soft received symbols, one field per rail |
| dec_bit | input | 1 | Decoded bit from the decoder |
| dec_valid | input | 1 | Qualifies `dec_bit` |
| ber | output | CNT_W | Error count of the last completed window |
| ber_valid | output | 1 | One-cycle strobe when `ber` is updated |

## Verification
A channel corruption applied to the symbols driven before edge n is counted at edge n+DEC_LATENCY+1. That is one cycle for the re-encoder register after the matching decoded bit arrives. The count then appears on `ber` after the edge that closes the window containing that counting edge. The bench numbers edges from reset release. For every corrupted slot it books the expected mismatch count against that exact future edge, and it sums those bookings per window. It samples the outputs on the falling edge after each rising edge, checks the strobe and value at window-closing edges and checks that the value holds at all other edges. A second instance with a narrow count and unsigned slicing, fed offset-binary copies of the same symbols, covers saturation and the other slicing rule.

// File: rtl/ber_pkg.sv
package ber_pkg;

    typedef enum logic {
        SLICE_SIGNED   = 1'b0,
        SLICE_UNSIGNED = 1'b1
    } slice_mode_e;

    // Saturating add clamped at lim.
    function automatic logic [31:0] sat_add(logic [31:0] a, logic [31:0] b, logic [31:0] lim);
        logic [32:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s > {1'b0, lim}) return lim;
        return s[31:0];
    endfunction

endpackage

// File: rtl/ber_slicer.sv
module ber_slicer #(
    parameter int                  N_RAIL = 2,
    parameter int                  SOFT_W = 3,
    parameter ber_pkg::slice_mode_e MODE  = ber_pkg::SLICE_SIGNED
) (
    input  logic [N_RAIL*SOFT_W-1:0] soft_i,
    output logic [N_RAIL-1:0]        hard_o
);
    for (genvar r = 0; r < N_RAIL; r++) begin : g_rail
        if (MODE == ber_pkg::SLICE_SIGNED) begin : g_sgn
            // non-negative -> 1 (R1)
            assign hard_o[r] = ~soft_i[r*SOFT_W + SOFT_W - 1];
        end else begin : g_uns
            assign hard_o[r] = soft_i[r*SOFT_W + SOFT_W - 1];
        end
    end
endmodule

// File: rtl/ber_delay_line.sv
module ber_delay_line #(
    parameter int N_RAIL = 2,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_RAIL-1:0] bits_i,
    output logic [N_RAIL-1:0] bits_o
);
    typedef struct packed {
        logic [DEPTH-1:0][N_RAIL-1:0] taps;
    } dl_s;

    dl_s st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.taps[0] = bits_i;
        for (int i = 1; i < DEPTH; i++) begin
            st_d.taps[i] = st_q.taps[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits_o = st_q.taps[DEPTH-1];
endmodule

// File: rtl/ber_reencoder.sv
module ber_reencoder #(
    parameter int                  K       = 3,
    parameter int                  N_RAIL  = 2,
    parameter logic [N_RAIL*K-1:0] GENPOLY = 6'b101_111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_bit_i,
    input  logic              dec_valid_i,
    output logic [N_RAIL-1:0] code_o,
    output logic              code_vld_o
);
    localparam int ST_W = K - 1;

    typedef struct packed {
        logic [ST_W-1:0]   hist;
        logic [N_RAIL-1:0] code;
        logic              vld;
    } enc_s;

    enc_s       st_d, st_q;
    logic [K-1:0] span;

    always_comb begin
        st_d = st_q;
        span = {dec_bit_i, st_q.hist};
        for (int r = 0; r < N_RAIL; r++) begin
            st_d.code[r] = ^(GENPOLY[r*K +: K] & span);
        end
        st_d.vld = dec_valid_i;
        if (dec_valid_i) begin
            st_d.hist = span[K-1:1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_o     = st_q.code;
    assign code_vld_o = st_q.vld;

    // R2: history moves only with a qualified bit
    assert_hist_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |=> $stable(st_q.hist));
endmodule

// File: rtl/ber_window_counter.sv
module ber_window_counter #(
    parameter int WIN_LOG2 = 5,
    parameter int CNT_W    = 16,
    parameter int MW       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MW-1:0]    mism_i,
    output logic [CNT_W-1:0] ber_o,
    output logic             ber_valid_o
);
    localparam logic [31:0] CNT_MAX = 32'((64'd1 << CNT_W) - 64'd1);

    typedef struct packed {
        logic [WIN_LOG2-1:0] win;
        logic [CNT_W-1:0]    acc;
        logic [CNT_W-1:0]    ber;
        logic                pulse;
    } win_s;

    win_s        st_d, st_q;
    logic [31:0] sum;
    logic        last;

    always_comb begin
        st_d  = st_q;
        sum   = ber_pkg::sat_add(32'(st_q.acc), 32'(mism_i), CNT_MAX);
        last  = &st_q.win;
        st_d.win   = st_q.win + 1'b1;
        st_d.pulse = last;
        if (last) begin
            st_d.ber = sum[CNT_W-1:0];
            st_d.acc = '0;
        end else begin
            st_d.acc = sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ber_o       = st_q.ber;
    assign ber_valid_o = st_q.pulse;

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |=> !st_q.pulse);

    assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.pulse |-> $stable(st_q.ber));

    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(&st_q.win) |=> st_q.acc >= $past(st_q.acc));
endmodule

// File: rtl/ber_monitor.sv
module ber_monitor #(
    parameter int                   K           = 3,
    parameter int                   N_RAIL      = 2,
    parameter logic [N_RAIL*K-1:0]  GENPOLY     = 6'b101_111,
    parameter int                   SOFT_W      = 3,
    parameter ber_pkg::slice_mode_e SLICE_MODE  = ber_pkg::SLICE_SIGNED,
    parameter int                   DEC_LATENCY = 3,
    parameter int                   WIN_LOG2    = 5,
    parameter int                   CNT_W       = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_RAIL*SOFT_W-1:0] rx_sym,
    input  logic                     dec_bit,
    input  logic                     dec_valid,
    output logic [CNT_W-1:0]         ber,
    output logic                     ber_valid
);
    localparam int ENC_DEPTH = 1;
    localparam int DELAY     = DEC_LATENCY + ENC_DEPTH;
    localparam int MW        = $clog2(N_RAIL + 1);

    logic [N_RAIL-1:0] hard, aligned, code;
    logic              code_vld;
    logic [MW-1:0]     mism;

    ber_slicer #(.N_RAIL(N_RAIL), .SOFT_W(SOFT_W), .MODE(SLICE_MODE)) slicer_i (
        .soft_i (rx_sym),
        .hard_o (hard)
    );

    ber_delay_line #(.N_RAIL(N_RAIL), .DEPTH(DELAY)) delay_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .bits_i (hard),
        .bits_o (aligned)
    );

    ber_reencoder #(.K(K), .N_RAIL(N_RAIL), .GENPOLY(GENPOLY)) enc_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .dec_bit_i   (dec_bit),
        .dec_valid_i (dec_valid),
        .code_o      (code),
        .code_vld_o  (code_vld)
    );

    // R4: rails that disagree, only for qualified slots
    assign mism = code_vld ? MW'($countones(code ^ aligned)) : '0;

    ber_window_counter #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W), .MW(MW)) win_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mism_i      (mism),
        .ber_o       (ber),
        .ber_valid_o (ber_valid)
    );
endmodule

// File: tb/ber_monitor_tb.sv
`timescale 1ns/1ps
module ber_monitor_tb_top;
    localparam int SW   = 3;
    localparam int LAT  = 3;
    localparam int WL2  = 5;
    localparam int WIN  = 1 << WL2;
    localparam int SATW = 3;
    localparam int SATM = (1 << SATW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2*SW-1:0] rx_sym = '0;
    logic [2*SW-1:0] rx_uns;
    logic dec_bit = 1'b0, dec_valid = 1'b0;
    logic [15:0] ber_m;
    logic        bv_m;
    logic [SATW-1:0] ber_s;
    logic            bv_s;

    always #2 clk = ~clk;

    // offset-binary copy for the unsigned instance
    assign rx_uns = {~rx_sym[2*SW-1], rx_sym[2*SW-2:SW], ~rx_sym[SW-1], rx_sym[SW-2:0]};

    ber_monitor #(.DEC_LATENCY(LAT), .WIN_LOG2(WL2)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_sym(rx_sym), .dec_bit(dec_bit),
        .dec_valid(dec_valid), .ber(ber_m), .ber_valid(bv_m));

    ber_monitor #(.DEC_LATENCY(LAT), .WIN_LOG2(WL2), .CNT_W(SATW),
                  .SLICE_MODE(ber_pkg::SLICE_UNSIGNED)) sat_i (
        .clk(clk), .rst_n(rst_n), .rx_sym(rx_uns), .dec_bit(dec_bit),
        .dec_valid(dec_valid), .ber(ber_s), .ber_valid(bv_s));

    int nchk = 0, nfail = 0;
    int cyc = 0, mode = 0, dcount = 0;
    string tag = "R7";
    logic [6:0] lf = 7'h5A;
    logic tp1 = 1'b0, tp2 = 1'b0;
    logic sv [64];
    logic sb [64];
    int   sf [64];
    int   pend [64];
    int   exp_acc = 0, last_m = 0, last_s = 0;

    task automatic chk(string t, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] soft_of(logic b, int c);
        if (b) begin
            case (c % 3) 0: return 3'd3; 1: return 3'd1; default: return 3'd0; endcase
        end else begin
            case (c % 3) 0: return 3'b100; 1: return 3'b111; default: return 3'b110; endcase
        end
    endfunction

    // one cycle: check results of the edge just passed, then drive the next slot
    task automatic step();
        logic vld, b, c0, c1, f0, f1;
        int k, j;
        if (cyc > 0) begin
            k = cyc - 1;
            exp_acc += pend[k % 64];
            pend[k % 64] = 0;
            if (k % WIN == WIN - 1) begin
                last_m = exp_acc;
                last_s = (exp_acc > SATM) ? SATM : exp_acc;
                exp_acc = 0;
                chk({tag, " R5 strobe"}, int'(bv_m), 1);
                chk({tag, " R5 count"}, int'(ber_m), last_m);
                chk({tag, " R1 R6 narrow count"}, int'(ber_s), last_s);
                chk({tag, " R5 narrow strobe"}, int'(bv_s), 1);
            end else begin
                chk({tag, " R5 no strobe"}, int'(bv_m), 0);
                chk({tag, " R7 hold"}, int'(ber_m), last_m);
                chk({tag, " R7 narrow hold"}, int'(ber_s), last_s);
            end
        end
        vld = !(mode == 3 && (cyc % 2 == 1));
        f0 = 1'b0; f1 = 1'b0; b = 1'b0;
        if (vld) begin
            b  = lf[0];
            lf = {lf[5:0], lf[6] ^ lf[5]};
            c0 = b ^ tp1 ^ tp2;
            c1 = b ^ tp2;
            tp2 = tp1; tp1 = b;
            if (mode == 1) f0 = (dcount % 4 == 0);
            if (mode == 4) f1 = (dcount % 3 == 0);
            if (mode == 2) begin f0 = 1'b1; f1 = 1'b1; end
            dcount++;
            rx_sym = {soft_of(c1 ^ f1, cyc + 1), soft_of(c0 ^ f0, cyc)};
        end else begin
            rx_sym = 6'(cyc * 37 + 5);
        end
        sv[cyc % 64] = vld;
        sb[cyc % 64] = b;
        sf[cyc % 64] = int'(f0) + int'(f1);
        if (cyc >= LAT) begin
            j = (cyc - LAT) % 64;
            dec_valid = sv[j];
            dec_bit   = sb[j];
            if (sv[j]) pend[(cyc + 1) % 64] += sf[j];
        end else begin
            dec_valid = 1'b0;
            dec_bit   = 1'b0;
        end
        cyc++;
    endtask

    task automatic run_windows(int n);
        for (int i = 0; i < n * WIN; i++) begin
            @(negedge clk);
            step();
        end
    endtask

    task automatic test_reset();
        tag = "R7";
        repeat (3) @(negedge clk);
        chk("R7 reset ber", int'(ber_m), 0);
        chk("R7 reset strobe", int'(bv_m), 0);
        chk("R7 reset narrow ber", int'(ber_s), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step();
        run_windows(1);
    endtask

    task automatic test_clean();
        mode = 0; tag = "R1 R2 R3 clean";
        run_windows(3);
        chk("R2 R3 clean window", int'(ber_m), 0);
    endtask

    task automatic test_rail0_sparse();
        mode = 1; tag = "R3 R4 rail0";
        run_windows(3);
        chk("R4 rail0 every 4th", int'(ber_m), 8);
    endtask

    task automatic test_rail1();
        mode = 4; tag = "R2 R4 rail1";
        run_windows(3);
    endtask

    task automatic test_all_flipped();
        mode = 2; tag = "R6 both rails";
        run_windows(3);
        chk("R4 both rails every slot", int'(ber_m), 2 * WIN);
        chk("R6 narrow saturated", int'(ber_s), SATM);
    endtask

    task automatic test_idle_gaps();
        mode = 3; tag = "R4 idle slots";
        run_windows(3);
        chk("R4 unqualified slots ignored", int'(ber_m), 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin pend[i] = 0; sv[i] = 1'b0; sb[i] = 1'b0; sf[i] = 0; end
        test_reset();
        test_clean();
        test_rail0_sparse();
        test_all_flipped();
        test_rail1();
        test_idle_gaps();
        test_clean();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule